// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Fully-Associative Victim Buffer

A direct-mapped, write-back, write-allocate data cache whose evicted lines are kept in a small fully-associative victim buffer instead of being dropped. A processor request is first looked up in the direct-mapped array. Only when that lookup misses is the victim buffer searched. A victim-buffer hit exchanges the buffer entry with the conflicting L1 line in a single extra cycle. When both structures miss, a line is fetched from the next memory level. The line it pushes out of L1 moves into the buffer. A dirty buffer entry that must make room is written back first.

The requester raises `req_i` with `addr_i`, `we_i` and `wdata_i`, and holds all four steady until `ready_o` is high in a cycle. Addresses are word addresses. The low `log2(LINE_WORDS)` bits select a word within a line, the next `log2(L1_SETS)` bits select the L1 set, and the remaining bits are the tag. The memory side uses a line-address fill request that stays up until `fill_valid_i` delivers the whole line. It also has a writeback channel that holds `wb_valid_o`, `wb_addr_o` and `wb_data_o` until `wb_ready_i`.

Top module: `vc_cache`

## Requirements
- R1: Every read returns the most recent value written to that word address, or the next-level contents if the word was never written.
- R2: When the addressed line is valid in L1, `ready_o` is high in the same cycle the request is presented. The victim buffer is left untouched and no fill or writeback starts.
- R3: When L1 misses and the victim buffer holds the line, the two lines swap places and `ready_o` rises exactly one cycle later, with no fill or writeback.
- R4: When both structures miss, `fill_req_o` rises the cycle after the request, with `fill_addr_o` equal to `addr_i` without its word-offset bits. `ready_o` follows one cycle after the cycle in which `fill_valid_i` is high. A valid displaced L1 line is kept in the victim buffer.
- R5: The victim buffer fills invalid entries first (lowest index first). Once it is full, it replaces its least recently written entry.
- R6: A dirty victim-buffer entry that is being replaced is presented on the writeback channel, with its line address and data, before the fill request. A clean replaced entry is discarded without memory traffic.
- R7: The dirty state of a line travels with it through swaps and through displacement into the buffer, so data written in L1 reaches memory on its later eviction.
- R8: Writes are write-allocate and write-back: a write that hits L1 causes no memory traffic.
- R9: After reset, every L1 line and every buffer entry is invalid. `ready_o`, `fill_req_o` and `wb_valid_o` are low, and the first access to any line misses.
- R10: While `fill_req_o` is high and `fill_valid_i` is low, the request and its address stay unchanged in the next cycle. While `wb_valid_o` is high and `wb_ready_i` is low, the same holds for `wb_valid_o` and `wb_addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Processor request, held until `ready_o` |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| ready_o | output | 1 | Request completes this cycle |
| rdata_o | output | DATA_W | Read data, valid with `ready_o` |
| fill_req_o | output | 1 | Line fill request |
| fill_addr_o | output | ADDR_W-log2(LINE_WORDS) | Line address to fetch |
| fill_valid_i | input | 1 | Fill line delivered this cycle |
| fill_data_i | input | DATA_W*LINE_WORDS | Fill line, word 0 in the low bits |
| wb_valid_o | output | 1 | Dirty line writeback request |
| wb_addr_o | output | ADDR_W-log2(LINE_WORDS) | Line address being written back |
| wb_data_o | output | DATA_W*LINE_WORDS | Line being written back |
| wb_ready_i | input | 1 | Writeback accepted this cycle |

## Verification
Each result has a fixed latency. An L1 hit answers in the request cycle. A victim-buffer swap answers one clock later. A full miss answers three clocks later with the bench's two-cycle fill responder, or five when a writeback with one stall cycle comes first. The bench applies each request just after a falling edge and counts rising edges until `ready_o` is seen, half a period after each edge. It compares that count with the latency the table expects for the step, and checks the read data and the fill and writeback counts at that moment. The memory responder acts only on falling edges, so a fill or writeback is accepted at a known rising edge.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WB,
    ST_FILL
  } vc_state_e;
endpackage

// File: rtl/vc_l1_store.sv
module vc_l1_store #(
  parameter int SETS   = 8,
  parameter int TAG_W  = 7,
  parameter int LINE_W = 128,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              wr_en_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic              wr_valid_i,
  input  logic              wr_dirty_i,
  input  logic [LINE_W-1:0] wr_line_i,
  output logic [TAG_W-1:0]  tag_o,
  output logic              valid_o,
  output logic              dirty_o,
  output logic [LINE_W-1:0] line_o
);
  logic [SETS-1:0]   valid_q, dirty_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] data_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en_i) begin
      valid_q[idx_i] <= wr_valid_i;
      dirty_q[idx_i] <= wr_dirty_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[idx_i]  <= wr_tag_i;
      data_q[idx_i] <= wr_line_i;
    end
  end

  assign tag_o   = tag_q[idx_i];
  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
  assign line_o  = data_q[idx_i];
endmodule

// File: rtl/vc_lru_age.sv
module vc_lru_age #(
  parameter int N = 4,
  localparam int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          touch_i,
  input  logic [AW-1:0] touch_idx_i,
  output logic [AW-1:0] oldest_o
);
  // ages form a permutation of 0..N-1; 0 = most recent
  logic [N-1:0][AW-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) age_q[i] <= AW'(i);
    end else if (touch_i) begin
      for (int i = 0; i < N; i++) begin
        if (AW'(i) == touch_idx_i)             age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx_i]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    oldest_o = '0;
    for (int i = 0; i < N; i++)
      if (age_q[i] == AW'(N-1)) oldest_o = AW'(i);
  end
endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf #(
  parameter int ENTRIES = 4,
  parameter int LA_W    = 10,
  parameter int LINE_W  = 128,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LA_W-1:0]    look_la_i,
  input  logic               wr_en_i,
  input  logic [IW-1:0]      wr_idx_i,
  input  logic               wr_valid_i,
  input  logic               wr_dirty_i,
  input  logic [LA_W-1:0]    wr_la_i,
  input  logic [LINE_W-1:0]  wr_line_i,
  output logic [ENTRIES-1:0] hit_vec_o,
  output logic               hit_o,
  output logic [IW-1:0]      hit_idx_o,
  output logic               hit_dirty_o,
  output logic [LINE_W-1:0]  hit_line_o,
  output logic [IW-1:0]      vic_idx_o,
  output logic               vic_valid_o,
  output logic               vic_dirty_o,
  output logic [LA_W-1:0]    vic_la_o,
  output logic [LINE_W-1:0]  vic_line_o
);
  logic [ENTRIES-1:0] valid_q, dirty_q;
  logic [LA_W-1:0]    la_q   [ENTRIES];
  logic [LINE_W-1:0]  line_q [ENTRIES];
  logic [IW-1:0]      lru_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en_i) begin
      valid_q[wr_idx_i] <= wr_valid_i;
      dirty_q[wr_idx_i] <= wr_dirty_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      la_q[wr_idx_i]   <= wr_la_i;
      line_q[wr_idx_i] <= wr_line_i;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec_o[g] = valid_q[g] && (la_q[g] == look_la_i);
  end

  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec_o[i]) hit_idx_o = IW'(i);
  end

  assign hit_o       = |hit_vec_o;
  assign hit_dirty_o = dirty_q[hit_idx_o];
  assign hit_line_o  = line_q[hit_idx_o];

  vc_lru_age #(.N(ENTRIES)) u_lru (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .touch_i    (wr_en_i),
    .touch_idx_i(wr_idx_i),
    .oldest_o   (lru_idx)
  );

  // free slot first, else least recently written
  always_comb begin
    logic found;
    found     = 1'b0;
    vic_idx_o = lru_idx;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found && !valid_q[i]) begin
        vic_idx_o = IW'(i);
        found     = 1'b1;
      end
    end
  end

  assign vic_valid_o = valid_q[vic_idx_o];
  assign vic_dirty_o = dirty_q[vic_idx_o];
  assign vic_la_o    = la_q[vic_idx_o];
  assign vic_line_o  = line_q[vic_idx_o];
endmodule

// File: rtl/vc_cache.sv
module vc_cache
  import vc_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int L1_SETS    = 8,
  parameter int VB_ENTRIES = 4,
  localparam int OFF_W  = $clog2(LINE_WORDS),
  localparam int IDX_W  = $clog2(L1_SETS),
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
  localparam int LA_W   = ADDR_W - OFF_W,
  localparam int LINE_W = DATA_W * LINE_WORDS,
  localparam int VIW    = $clog2(VB_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              fill_req_o,
  output logic [LA_W-1:0]   fill_addr_o,
  input  logic              fill_valid_i,
  input  logic [LINE_W-1:0] fill_data_i,
  output logic              wb_valid_o,
  output logic [LA_W-1:0]   wb_addr_o,
  output logic [LINE_W-1:0] wb_data_o,
  input  logic              wb_ready_i
);
  vc_state_e state_q, state_d;

  logic [OFF_W-1:0] off;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic [LA_W-1:0]  la;
  assign off = addr_i[OFF_W-1:0];
  assign idx = addr_i[OFF_W +: IDX_W];
  assign tag = addr_i[ADDR_W-1 -: TAG_W];
  assign la  = addr_i[ADDR_W-1:OFF_W];

  logic [TAG_W-1:0]  l1_tag;
  logic              l1_valid, l1_dirty, l1_hit;
  logic [LINE_W-1:0] l1_line, merged;
  logic              l1_wr;
  logic [TAG_W-1:0]  l1_wr_tag;
  logic              l1_wr_dirty;
  logic [LINE_W-1:0] l1_wr_line;

  logic [VB_ENTRIES-1:0] vb_hit_vec;
  logic                  vb_hit, vb_hit_dirty, vb_vic_valid, vb_vic_dirty;
  logic [VIW-1:0]        vb_hit_idx, vb_vic_idx, vb_wr_idx;
  logic [LINE_W-1:0]     vb_hit_line, vb_vic_line;
  logic [LA_W-1:0]       vb_vic_la;
  logic                  vb_wr_en;

  logic idle, swap_go, miss_go, fill_done;

  vc_l1_store #(.SETS(L1_SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_l1 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idx_i     (idx),
    .wr_en_i   (l1_wr),
    .wr_tag_i  (l1_wr_tag),
    .wr_valid_i(1'b1),
    .wr_dirty_i(l1_wr_dirty),
    .wr_line_i (l1_wr_line),
    .tag_o     (l1_tag),
    .valid_o   (l1_valid),
    .dirty_o   (l1_dirty),
    .line_o    (l1_line)
  );

  vc_victim_buf #(.ENTRIES(VB_ENTRIES), .LA_W(LA_W), .LINE_W(LINE_W)) u_vb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .look_la_i  (la),
    .wr_en_i    (vb_wr_en),
    .wr_idx_i   (vb_wr_idx),
    .wr_valid_i (l1_valid),
    .wr_dirty_i (l1_dirty),
    .wr_la_i    ({l1_tag, idx}),
    .wr_line_i  (l1_line),
    .hit_vec_o  (vb_hit_vec),
    .hit_o      (vb_hit),
    .hit_idx_o  (vb_hit_idx),
    .hit_dirty_o(vb_hit_dirty),
    .hit_line_o (vb_hit_line),
    .vic_idx_o  (vb_vic_idx),
    .vic_valid_o(vb_vic_valid),
    .vic_dirty_o(vb_vic_dirty),
    .vic_la_o   (vb_vic_la),
    .vic_line_o (vb_vic_line)
  );

  assign idle      = (state_q == ST_IDLE);
  assign l1_hit    = l1_valid && (l1_tag == tag);
  assign ready_o   = idle && req_i && l1_hit;
  assign rdata_o   = l1_line[DATA_W*off +: DATA_W];
  assign swap_go   = idle && req_i && !l1_hit && vb_hit;
  assign miss_go   = idle && req_i && !l1_hit && !vb_hit;
  assign fill_done = (state_q == ST_FILL) && fill_valid_i;

  always_comb begin
    merged = l1_line;
    merged[DATA_W*off +: DATA_W] = wdata_i;
  end

  // L1 write: write hit, swap-in, or refill
  always_comb begin
    l1_wr       = 1'b0;
    l1_wr_tag   = tag;
    l1_wr_dirty = 1'b0;
    l1_wr_line  = fill_data_i;
    if (ready_o && we_i) begin
      l1_wr       = 1'b1;
      l1_wr_dirty = 1'b1;
      l1_wr_line  = merged;
    end else if (swap_go) begin
      l1_wr       = 1'b1;
      l1_wr_dirty = vb_hit_dirty;
      l1_wr_line  = vb_hit_line;
    end else if (fill_done) begin
      l1_wr = 1'b1;
    end
  end

  // buffer takes the old L1 line on swap or displacement
  assign vb_wr_en  = swap_go || (fill_done && l1_valid);
  assign vb_wr_idx = swap_go ? vb_hit_idx : vb_vic_idx;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (miss_go)
                 state_d = (l1_valid && vb_vic_valid && vb_vic_dirty) ? ST_WB : ST_FILL;
      ST_WB:   if (wb_ready_i) state_d = ST_FILL;
      ST_FILL: if (fill_valid_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign fill_req_o  = (state_q == ST_FILL);
  assign fill_addr_o = la;
  assign wb_valid_o  = (state_q == ST_WB);
  assign wb_addr_o   = vb_vic_la;
  assign wb_data_o   = vb_vic_line;
endmodule

// File: rtl/vc_cache_chk.sv
module vc_cache_chk #(
  parameter int LA_W       = 10,
  parameter int VB_ENTRIES = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_i,
  input logic                  ready_o,
  input logic                  idle,
  input logic                  l1_hit,
  input logic                  vb_hit,
  input logic [VB_ENTRIES-1:0] vb_hit_vec,
  input logic                  vb_wr_en,
  input logic                  fill_req_o,
  input logic [LA_W-1:0]       fill_addr_o,
  input logic                  fill_valid_i,
  input logic                  wb_valid_o,
  input logic [LA_W-1:0]       wb_addr_o,
  input logic                  wb_ready_i
);
  AST_HIT_KEEPS_VB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !vb_wr_en); // R2

  AST_SWAP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && req_i && !l1_hit && vb_hit) |=> (ready_o || !req_i)); // R3

  AST_NO_DUPLICATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && l1_hit) |-> !vb_hit); // R4

  AST_VB_SINGLE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(vb_hit_vec)); // R5

  AST_WB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && !wb_ready_i) |=> (wb_valid_o && $stable(wb_addr_o))); // R10

  AST_FILL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && !fill_valid_i) |=> (fill_req_o && $stable(fill_addr_o))); // R10

  AST_WB_BEFORE_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> !fill_req_o); // R6
endmodule

bind vc_cache vc_cache_chk #(.LA_W(LA_W), .VB_ENTRIES(VB_ENTRIES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .ready_o     (ready_o),
  .idle        (idle),
  .l1_hit      (l1_hit),
  .vb_hit      (vb_hit),
  .vb_hit_vec  (vb_hit_vec),
  .vb_wr_en    (vb_wr_en),
  .fill_req_o  (fill_req_o),
  .fill_addr_o (fill_addr_o),
  .fill_valid_i(fill_valid_i),
  .wb_valid_o  (wb_valid_o),
  .wb_addr_o   (wb_addr_o),
  .wb_ready_i  (wb_ready_i)
);

// File: tb/tb_vc_cache.sv
`timescale 1ns/1ps
module tb_vc_cache;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int WORDS  = 4;
  localparam int LA_W   = ADDR_W - 2;
  localparam int LINE_W = DATA_W * WORDS;
  localparam int NSTEP  = 17;

  logic              clk, rst_n;
  logic              req_i, we_i;
  logic [ADDR_W-1:0] addr_i;
  logic [DATA_W-1:0] wdata_i;
  logic              ready_o;
  logic [DATA_W-1:0] rdata_o;
  logic              fill_req_o, fill_valid_i;
  logic [LA_W-1:0]   fill_addr_o, wb_addr_o;
  logic [LINE_W-1:0] fill_data_i, wb_data_o;
  logic              wb_valid_o, wb_ready_i;

  vc_cache dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .ready_o(ready_o), .rdata_o(rdata_o),
    .fill_req_o(fill_req_o), .fill_addr_o(fill_addr_o), .fill_valid_i(fill_valid_i),
    .fill_data_i(fill_data_i), .wb_valid_o(wb_valid_o), .wb_addr_o(wb_addr_o),
    .wb_data_o(wb_data_o), .wb_ready_i(wb_ready_i)
  );

  typedef struct packed {
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [3:0]        lat;  // 0 hit, 1 swap, 3 miss, 5 miss with writeback
  } vec_t;

  // lines 0x024,0x044,... all share set 1; LRU order worked out by hand
  localparam vec_t TBL [NSTEP] = '{
    '{1'b0, 12'h024, 32'h0, 4'd3},        // cold miss
    '{1'b0, 12'h025, 32'h0, 4'd0},        // same line hit
    '{1'b0, 12'h044, 32'h0, 4'd3},        // conflict, 024 line to buffer
    '{1'b0, 12'h026, 32'h0, 4'd1},        // ping-pong swap
    '{1'b0, 12'h045, 32'h0, 4'd1},        // ping-pong swap
    '{1'b1, 12'h024, 32'hA0A0_0001, 4'd1},// write after swap, dirty
    '{1'b0, 12'h024, 32'h0, 4'd0},
    '{1'b0, 12'h064, 32'h0, 4'd3},        // dirty line to buffer slot 1
    '{1'b0, 12'h084, 32'h0, 4'd3},
    '{1'b0, 12'h0A4, 32'h0, 4'd3},        // buffer now full
    '{1'b0, 12'h0C4, 32'h0, 4'd3},        // LRU clean entry dropped
    '{1'b0, 12'h0E4, 32'h0, 4'd5},        // LRU dirty entry written back
    '{1'b0, 12'h024, 32'h0, 4'd3},        // refetch written data
    '{1'b0, 12'h044, 32'h0, 4'd3},
    '{1'b0, 12'h000, 32'h0, 4'd3},        // other set
    '{1'b1, 12'h001, 32'hB0B0_0002, 4'd0},// write hit, no traffic
    '{1'b0, 12'h001, 32'h0, 4'd0}
  };

  logic [DATA_W-1:0] mem  [1<<ADDR_W];
  logic [DATA_W-1:0] refm [1<<ADDR_W];
  int errors = 0, checks = 0;
  int fills = 0, wbs = 0, fcnt = 0, wseen = 0;
  logic [LA_W-1:0]   last_wb_addr;
  logic [DATA_W-1:0] last_wb_w0;

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic string lat_req(input int lat);
    case (lat)
      0:       return "R2";
      1:       return "R3";
      5:       return "R6";
      default: return "R4";
    endcase
  endfunction

  // next-level memory: fill after two falling edges, writeback after one stall
  initial begin
    fill_valid_i = 1'b0;
    wb_ready_i   = 1'b0;
    fill_data_i  = '0;
    forever begin
      @(negedge clk);
      fill_valid_i = 1'b0;
      wb_ready_i   = 1'b0;
      if (!rst_n) begin
        fcnt = 0;
        wseen = 0;
      end else begin
        if (fill_req_o) begin
          fcnt++;
          if (fcnt == 2) begin
            fill_valid_i = 1'b1;
            for (int w = 0; w < WORDS; w++)
              fill_data_i[w*DATA_W +: DATA_W] = mem[{fill_addr_o, 2'(w)}];
            fcnt = 0;
            fills++;
          end
        end
        if (wb_valid_o) begin
          if (wseen != 0) begin
            wb_ready_i = 1'b1;
            for (int w = 0; w < WORDS; w++)
              mem[{wb_addr_o, 2'(w)}] = wb_data_o[w*DATA_W +: DATA_W];
            last_wb_addr = wb_addr_o;
            last_wb_w0   = wb_data_o[DATA_W-1:0];
            wbs++;
            wseen = 0;
          end else begin
            wseen = 1;
          end
        end
      end
    end
  end

  task automatic access(input logic we, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] wd, output int cyc,
                        output logic [DATA_W-1:0] rd);
    @(negedge clk);
    req_i = 1'b1; we_i = we; addr_i = a; wdata_i = wd;
    cyc = 0;
    rd  = '0;
    forever begin
      #1;
      if (ready_o) break;
      if (cyc > 40) break;
      @(negedge clk);
      cyc++;
    end
    rd = rdata_o;
    @(posedge clk);
    #1 req_i = 1'b0;
    if (we) refm[a] = wd;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R1", "watchdog", 32'h0, 32'h1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cyc, f0, w0;
    logic [DATA_W-1:0] rd;
    for (int i = 0; i < (1 << ADDR_W); i++) begin
      mem[i]  = 32'h5A00_0000 | i;
      refm[i] = 32'h5A00_0000 | i;
    end
    req_i = 1'b0; we_i = 1'b0; addr_i = '0; wdata_i = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R9: idle outputs under reset
    check(!ready_o && !fill_req_o && !wb_valid_o, "R9", "outputs in reset",
          {29'h0, ready_o, fill_req_o, wb_valid_o}, 32'h0);
    rst_n = 1'b1;

    for (int s = 0; s < NSTEP; s++) begin
      f0 = fills; w0 = wbs;
      access(TBL[s].we, TBL[s].addr, TBL[s].wdata, cyc, rd);
      check(cyc == int'(TBL[s].lat), lat_req(int'(TBL[s].lat)),
            $sformatf("step %0d latency", s), cyc, TBL[s].lat);
      if (!TBL[s].we)
        check(rd == refm[TBL[s].addr], "R1", $sformatf("step %0d read data", s),
              rd, refm[TBL[s].addr]);
      // R8: hits and swaps (reads or writes) cause no fill
      check((fills - f0) == ((TBL[s].lat >= 4'd3) ? 1 : 0),
            TBL[s].we ? "R8" : lat_req(int'(TBL[s].lat)),
            $sformatf("step %0d fill count", s), fills - f0, (TBL[s].lat >= 4'd3) ? 1 : 0);
      check((wbs - w0) == ((TBL[s].lat == 4'd5) ? 1 : 0), "R6",
            $sformatf("step %0d writeback count", s), wbs - w0, (TBL[s].lat == 4'd5) ? 1 : 0);
    end

    // R6 / R7: the dirty line swapped back and forth left with its write
    check(last_wb_addr == 10'h009, "R6", "writeback line address", last_wb_addr, 32'h9);
    check(last_wb_w0 == 32'hA0A0_0001, "R7", "writeback data", last_wb_w0, 32'hA0A0_0001);
    check(wbs == 1, "R5", "clean LRU victims dropped silently", wbs, 1);

    // R9: reset mid-run invalidates everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    access(1'b0, 12'h024, 32'h0, cyc, rd);
    check(cyc == 3, "R9", "miss after reset", cyc, 3);
    check(rd == 32'hA0A0_0001, "R1", "written-back data persists", rd, 32'hA0A0_0001);
    access(1'b0, 12'h044, 32'h0, cyc, rd);
    check(cyc == 3, "R9", "buffer empty after reset", cyc, 3);
    access(1'b0, 12'h026, 32'h0, cyc, rd);
    check(cyc == 1, "R3", "ping-pong swap after reset", cyc, 1);
    check(rd == refm[12'h026], "R1", "swap read data", rd, refm[12'h026]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule